// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block finds the divider settings for a frequency synthesizer. Software or a clock controller gives it a reference frequency and a requested output frequency, both in kHz. The block then walks the allowed settings one candidate at a time. The settings are the reference divider M, the feedback multiplier N and a post-divider index PL. It returns the combination whose rounded output lands closest to the request, together with the frequency that combination actually produces. The limits it must respect are parameters of the block: output range, VCO range, comparison-frequency (u = ref/M) range, and the M, N and post-divide ranges.

The post-divider is addressed through a 15-entry index table whose divide values are not monotonic. Before the loops start, the search converts a high and a low divide bound into table indices. The loops then prune whole branches: the M loop ends once the comparison frequency falls too low, and it also ends once the lowest N candidate is already too large. Two modes are offered. Best-fit mode searches everything that survives pruning. Fast mode accepts the first improvement whose VCO-to-error ratio is above 218.

The engine is built around one shared bit-serial divider and a single state machine. It idles in `S_IDLE`. It sets up bounds in `S_T50_GO/WT`, `S_HI_GO/WT`, `S_LO_GO/WT` and `S_PL_INIT`. It loops over PL in `S_M_INIT` and `S_PL_NEXT`, over M in `S_M_CHK` and `S_M_INC`, and over N in `S_N_GO/WT`, `S_N_CHK`, `S_N_LOOP` and `S_N_INC`. It evaluates each candidate in `S_V_GO/WT`, `S_V_CHK`, `S_L_GO/WT` and `S_EVAL`. It computes the final frequency in `S_F_GO/WT` and publishes the result in `S_FIN`.

The transitions are as follows:
- Start in idle goes to `S_T50_GO`.
- Each `*_GO` state goes to its `*_WT` state. Each `*_WT` state moves on when the divider finishes.
- `S_PL_INIT` goes to `S_F_GO` if the low index exceeds the high index, and otherwise to `S_M_INIT`.
- `S_M_CHK` goes to `S_PL_NEXT` when M is past its maximum or u is below its minimum. It goes to `S_M_INC` when u is above its maximum, and otherwise to `S_N_GO`.
- `S_N_CHK` goes to `S_PL_NEXT` when the floor N is above its maximum, and otherwise to `S_N_LOOP`.
- `S_N_LOOP` goes to `S_M_INC` when N passes the ceiling or the maximum. It goes to `S_N_INC` when N is below its minimum, and otherwise to `S_V_GO`.
- `S_V_CHK` goes to `S_L_GO` for a VCO inside the range, and otherwise to `S_N_INC`.
- `S_EVAL` goes to `S_F_GO` on an improvement that meets the stop rule, and otherwise to `S_N_INC`.
- `S_PL_NEXT` goes to `S_F_GO` after the high index, and otherwise back to `S_M_INIT`.
- `S_FIN` returns to `S_IDLE`.

Top module: `pll_coef_search`

## Requirements
- R1: While reset is held and right after it, busy, done and no_sol are 0, and m_out, n_out, pl_out and freq_out are 0.
- R2: A start pulse while busy is 0 captures ref_khz, target_khz and fast_mode, raises busy and clears done on the next cycle. A start pulse while busy is 1 is ignored, and the result belongs to the first request.
- R3: Before the search, the target is clamped into [F_MIN, F_MAX] (defaults 144000 and 2064000 kHz).
- R4: PL index i selects a divide value from the list 1,2,3,4,5,6,8,10,12,16,12,16,20,24,32 (i = 0 to 14). pl_out reports the index, not the divide value.
- R5: The margin VCO value is target + floor(target/50). The upper VCO limit is raised to this value when it is lower. The high bound is ceil(upper limit / margin value) and the low bound is floor(VCO_MIN / margin value). Each bound is clamped into [PL_MIN, PL_MAX] and mapped to the lowest index in 0 to 13 whose divide value is at least the bound, or to 13 if no index qualifies.
- R6: For each PL from the low index to the high index, M runs from M_MIN to M_MAX. If floor(ref/M) is below U_MIN, the M loop ends. If it is above U_MAX, that M is skipped.
- R7: With P = target·div[PL]·M, the N candidates run from floor(P/ref) to ceil(P/ref). If the floor exceeds N_MAX, the M loop ends. A candidate below N_MIN is skipped, and a candidate above N_MAX ends the N loop.
- R8: A candidate is valid only if vco = floor(ref·N/M) lies within [VCO_MIN, upper limit]. Its output is floor((vco + floor(div/2))/div), and its error is the absolute difference from the clamped target.
- R9: A valid candidate replaces the best only when its error is strictly smaller, so the first one found wins a tie. A new best with zero error ends the search.
- R10: When fast_mode is 1, a new best with floor(vco/error) > 218 also ends the search. When fast_mode is 0, the search continues past it.
- R11: If no valid candidate exists, no_sol is 1 and the result is M = M_MAX, N = N_MIN and PL index = PL_MIN (255, 8 and 1 by default).
- R12: done stays 1, and the outputs stay constant, until the next accepted start. While busy is 1, the outputs do not change.
- R13: freq_out = floor(ref·N / (M·div[PL])) for the reported M, N and PL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a search; sampled only when idle |
| fast_mode | input | 1 | 1 = stop early at ratio threshold, 0 = best fit |
| ref_khz | input | FW | Reference frequency in kHz |
| target_khz | input | FW | Requested output frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | Result valid, held until next start |
| no_sol | output | 1 | No valid candidate was found |
| m_out | output | MW | Chosen reference divider |
| n_out | output | NW | Chosen feedback multiplier |
| pl_out | output | 4 | Chosen post-divider table index |
| freq_out | output | FW | Achieved output frequency in kHz |

## Verification
The bound checker watches the handshake and the ranges on every cycle:
- an idle start raising busy;
- done and busy never being high together;
- done holding and the outputs staying frozen while a search runs;
- every published result lying inside the M, N and PL limits, or equalling the defaults when no_sol is set.

Only the bench scenarios can show which candidate wins. That covers target clamping, the raised VCO ceiling, pruning by u, tie-breaking, and fast mode stopping earlier than best-fit mode on the same request. Each scenario is compared against values worked out by hand.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

    localparam int unsigned PL_IDX_W = 4;
    localparam int unsigned PL_SCAN  = 14;   // indices searched when mapping a bound

    // Post-divider table: index -> divide value (not monotonic above index 9)
    function automatic logic [5:0] pl_div(input logic [PL_IDX_W-1:0] idx);
        logic [5:0] d;
        case (idx)
            4'd0:    d = 6'd1;
            4'd1:    d = 6'd2;
            4'd2:    d = 6'd3;
            4'd3:    d = 6'd4;
            4'd4:    d = 6'd5;
            4'd5:    d = 6'd6;
            4'd6:    d = 6'd8;
            4'd7:    d = 6'd10;
            4'd8:    d = 6'd12;
            4'd9:    d = 6'd16;
            4'd10:   d = 6'd12;
            4'd11:   d = 6'd16;
            4'd12:   d = 6'd20;
            4'd13:   d = 6'd24;
            4'd14:   d = 6'd32;
            default: d = 6'd1;
        endcase
        return d;
    endfunction

    typedef enum logic [4:0] {
        S_IDLE,
        S_T50_GO, S_T50_WT,
        S_HI_GO,  S_HI_WT,
        S_LO_GO,  S_LO_WT,
        S_PL_INIT,
        S_M_INIT, S_M_CHK,
        S_N_GO,   S_N_WT, S_N_CHK, S_N_LOOP,
        S_V_GO,   S_V_WT, S_V_CHK,
        S_L_GO,   S_L_WT,
        S_EVAL,
        S_N_INC,  S_M_INC, S_PL_NEXT,
        S_F_GO,   S_F_WT,
        S_FIN
    } srch_state_t;

endpackage

// File: rtl/pllsrch_div.sv
// Restoring bit-serial divider: W cycles per quotient, one-cycle done pulse.
module pllsrch_div #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int unsigned CW = $clog2(W + 1);

    logic [W-1:0]  rem_r, quo_r, den_r;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    shifted, diff;
    logic          fits;

    always_comb begin
        shifted = {rem_r, quo_r[W-1]};
        diff    = shifted - {1'b0, den_r};
        fits    = (shifted >= {1'b0, den_r});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_r <= '0;
            quo_r <= '0;
            den_r <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_r <= '0;
                quo_r <= num;
                den_r <= den;
                cnt   <= CW'(W);
                run   <= 1'b1;
            end else if (run) begin
                rem_r <= fits ? diff[W-1:0] : shifted[W-1:0];
                quo_r <= {quo_r[W-2:0], fits};
                cnt   <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = quo_r;
    assign rem = rem_r;
endmodule

// File: rtl/pllsrch_plidx.sv
// Clamp a divide bound and map it to the first table index (0..13) reaching it.
module pllsrch_plidx #(
    parameter int unsigned FW     = 32,
    parameter int unsigned PL_MIN = 1,
    parameter int unsigned PL_MAX = 32
) (
    input  logic [FW-1:0] bound,
    output logic [3:0]    idx
);
    import pllsrch_pkg::*;

    logic [FW-1:0]      bound_c;
    logic [PL_SCAN-1:0] hit;

    always_comb begin
        if (bound < FW'(PL_MIN))
            bound_c = FW'(PL_MIN);
        else if (bound > FW'(PL_MAX))
            bound_c = FW'(PL_MAX);
        else
            bound_c = bound;
    end

    for (genvar gi = 0; gi < PL_SCAN; gi++) begin : g_hit
        assign hit[gi] = (FW'(pl_div(4'(gi))) >= bound_c);
    end

    always_comb begin
        idx = 4'(PL_SCAN - 1);
        for (int i = PL_SCAN - 1; i >= 0; i--) begin
            if (hit[i]) idx = 4'(i);
        end
    end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search #(
    parameter int unsigned FW         = 32,
    parameter int unsigned MW         = 8,
    parameter int unsigned NW         = 8,
    parameter int unsigned F_MIN      = 144000,
    parameter int unsigned F_MAX      = 2064000,
    parameter int unsigned VCO_MIN    = 1000000,
    parameter int unsigned VCO_MAX    = 2064000,
    parameter int unsigned U_MIN      = 12000,
    parameter int unsigned U_MAX      = 38000,
    parameter int unsigned M_MIN      = 1,
    parameter int unsigned M_MAX      = 255,
    parameter int unsigned N_MIN      = 8,
    parameter int unsigned N_MAX      = 255,
    parameter int unsigned PL_MIN     = 1,
    parameter int unsigned PL_MAX     = 32,
    parameter int unsigned MARGIN_DIV = 50,
    parameter int unsigned FAST_RATIO = 218
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          fast_mode,
    input  logic [FW-1:0] ref_khz,
    input  logic [FW-1:0] target_khz,
    output logic          busy,
    output logic          done,
    output logic          no_sol,
    output logic [MW-1:0] m_out,
    output logic [NW-1:0] n_out,
    output logic [3:0]    pl_out,
    output logic [FW-1:0] freq_out
);
    import pllsrch_pkg::*;

    localparam int unsigned DW  = FW + 16;
    localparam int unsigned MCW = MW + 1;

    localparam logic [DW-1:0] K_VMIN   = DW'(VCO_MIN);
    localparam logic [DW-1:0] K_VMAX   = DW'(VCO_MAX);
    localparam logic [DW-1:0] K_UMIN   = DW'(U_MIN);
    localparam logic [DW-1:0] K_UMAX1  = DW'(U_MAX) + DW'(1);
    localparam logic [DW-1:0] K_NMIN   = DW'(N_MIN);
    localparam logic [DW-1:0] K_NMAX   = DW'(N_MAX);
    localparam logic [DW-1:0] K_MMAX   = DW'(M_MAX);
    localparam logic [DW-1:0] K_RATIO1 = DW'(FAST_RATIO) + DW'(1);
    localparam logic [DW-1:0] K_MARGIN = DW'(MARGIN_DIV);

    srch_state_t state, nstate;

    logic [DW-1:0]  ref_r, tgt_r, tvh_r, maxv_r, tvco_r;
    logic [DW-1:0]  n_r, n2_r, vco_r, err_r, best_err;
    logic [FW-1:0]  hib_r, lob_r, freq_r, tgt_clamped;
    logic [MCW-1:0] m_r;
    logic [3:0]     pl_r, lo_idx, hi_idx, best_pl;
    logic [MW-1:0]  best_m;
    logic [NW-1:0]  best_n;
    logic           found, fast_r;

    logic           dv_go, dv_done;
    logic [DW-1:0]  dv_num, dv_den, dv_quo, dv_rem;

    logic [DW-1:0]  m_ext, div_cur, tvh_sum, lwv_err;
    logic           u_low, u_high, vco_ok, better, stop_now;

    // ---------------------------------------------------------------
    // Shared divider and bound-to-index mappers
    // ---------------------------------------------------------------
    pllsrch_div #(.W(DW)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (dv_go),
        .num   (dv_num),
        .den   (dv_den),
        .done  (dv_done),
        .quo   (dv_quo),
        .rem   (dv_rem)
    );

    pllsrch_plidx #(.FW(FW), .PL_MIN(PL_MIN), .PL_MAX(PL_MAX)) i_hi_map (
        .bound (hib_r),
        .idx   (hi_idx)
    );

    pllsrch_plidx #(.FW(FW), .PL_MIN(PL_MIN), .PL_MAX(PL_MAX)) i_lo_map (
        .bound (lob_r),
        .idx   (lo_idx)
    );

    // ---------------------------------------------------------------
    // Candidate arithmetic
    // ---------------------------------------------------------------
    always_comb begin
        if (target_khz < FW'(F_MIN))
            tgt_clamped = FW'(F_MIN);
        else if (target_khz > FW'(F_MAX))
            tgt_clamped = FW'(F_MAX);
        else
            tgt_clamped = target_khz;

        m_ext    = DW'(m_r);
        div_cur  = DW'(pl_div(pl_r));
        tvh_sum  = tgt_r + dv_quo;
        u_low    = (ref_r < K_UMIN * m_ext);
        u_high   = (ref_r >= K_UMAX1 * m_ext);
        vco_ok   = (vco_r >= K_VMIN) && (vco_r <= maxv_r);
        lwv_err  = (dv_quo >= tgt_r) ? (dv_quo - tgt_r) : (tgt_r - dv_quo);
        better   = !found || (err_r < best_err);
        stop_now = (err_r == '0) || (fast_r && (vco_r >= K_RATIO1 * err_r));
    end

    // ---------------------------------------------------------------
    // State register
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // ---------------------------------------------------------------
    // Next state and divider issue
    // ---------------------------------------------------------------
    always_comb begin
        nstate = state;
        dv_go  = 1'b0;
        dv_num = '0;
        dv_den = DW'(1);
        unique case (state)
            S_IDLE:    if (start) nstate = S_T50_GO;
            S_T50_GO:  begin dv_go = 1'b1; dv_num = tgt_r; dv_den = K_MARGIN; nstate = S_T50_WT; end
            S_T50_WT:  if (dv_done) nstate = S_HI_GO;
            S_HI_GO:   begin dv_go = 1'b1; dv_num = maxv_r + tvh_r - DW'(1); dv_den = tvh_r; nstate = S_HI_WT; end
            S_HI_WT:   if (dv_done) nstate = S_LO_GO;
            S_LO_GO:   begin dv_go = 1'b1; dv_num = K_VMIN; dv_den = tvh_r; nstate = S_LO_WT; end
            S_LO_WT:   if (dv_done) nstate = S_PL_INIT;
            S_PL_INIT: nstate = (lo_idx > hi_idx) ? S_F_GO : S_M_INIT;
            S_M_INIT:  nstate = S_M_CHK;
            S_M_CHK: begin
                if ((m_ext > K_MMAX) || u_low) nstate = S_PL_NEXT;
                else if (u_high)               nstate = S_M_INC;
                else                           nstate = S_N_GO;
            end
            S_N_GO:    begin dv_go = 1'b1; dv_num = tvco_r * m_ext; dv_den = ref_r; nstate = S_N_WT; end
            S_N_WT:    if (dv_done) nstate = S_N_CHK;
            S_N_CHK:   nstate = (n_r > K_NMAX) ? S_PL_NEXT : S_N_LOOP;
            S_N_LOOP: begin
                if (n_r > n2_r)        nstate = S_M_INC;
                else if (n_r < K_NMIN) nstate = S_N_INC;
                else if (n_r > K_NMAX) nstate = S_M_INC;
                else                   nstate = S_V_GO;
            end
            S_V_GO:    begin dv_go = 1'b1; dv_num = ref_r * n_r; dv_den = m_ext; nstate = S_V_WT; end
            S_V_WT:    if (dv_done) nstate = S_V_CHK;
            S_V_CHK:   nstate = vco_ok ? S_L_GO : S_N_INC;
            S_L_GO:    begin dv_go = 1'b1; dv_num = vco_r + (div_cur >> 1); dv_den = div_cur; nstate = S_L_WT; end
            S_L_WT:    if (dv_done) nstate = S_EVAL;
            S_EVAL:    nstate = (better && stop_now) ? S_F_GO : S_N_INC;
            S_N_INC:   nstate = S_N_LOOP;
            S_M_INC:   nstate = S_M_CHK;
            S_PL_NEXT: nstate = (pl_r >= hi_idx) ? S_F_GO : S_M_INIT;
            S_F_GO: begin
                dv_go  = 1'b1;
                dv_num = ref_r * DW'(best_n);
                dv_den = DW'(best_m) * DW'(pl_div(best_pl));
                nstate = S_F_WT;
            end
            S_F_WT:    if (dv_done) nstate = S_FIN;
            S_FIN:     nstate = S_IDLE;
            default:   nstate = S_IDLE;
        endcase
    end

    // ---------------------------------------------------------------
    // Working registers
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_r    <= '0;
            tgt_r    <= '0;
            fast_r   <= 1'b0;
            tvh_r    <= DW'(1);
            maxv_r   <= K_VMAX;
            hib_r    <= '0;
            lob_r    <= '0;
            pl_r     <= '0;
            m_r      <= '0;
            tvco_r   <= '0;
            n_r      <= '0;
            n2_r     <= '0;
            vco_r    <= '0;
            err_r    <= '0;
            best_err <= '1;
            best_m   <= '0;
            best_n   <= '0;
            best_pl  <= '0;
            found    <= 1'b0;
            freq_r   <= '0;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    ref_r    <= DW'(ref_khz);
                    tgt_r    <= DW'(tgt_clamped);
                    fast_r   <= fast_mode;
                    best_m   <= MW'(M_MAX);
                    best_n   <= NW'(N_MIN);
                    best_pl  <= 4'(PL_MIN);
                    best_err <= '1;
                    found    <= 1'b0;
                end
                S_T50_WT: if (dv_done) begin
                    tvh_r  <= tvh_sum;
                    maxv_r <= (K_VMAX < tvh_sum) ? tvh_sum : K_VMAX;
                end
                S_HI_WT:   if (dv_done) hib_r <= dv_quo[FW-1:0];
                S_LO_WT:   if (dv_done) lob_r <= dv_quo[FW-1:0];
                S_PL_INIT: pl_r <= lo_idx;
                S_M_INIT: begin
                    m_r    <= MCW'(M_MIN);
                    tvco_r <= tgt_r * div_cur;
                end
                S_N_WT: if (dv_done) begin
                    n_r  <= dv_quo;
                    n2_r <= dv_quo + DW'(dv_rem != '0);
                end
                S_V_WT: if (dv_done) vco_r <= dv_quo;
                S_L_WT: if (dv_done) err_r <= lwv_err;
                S_EVAL: if (better) begin
                    best_err <= err_r;
                    best_m   <= MW'(m_r);
                    best_n   <= NW'(n_r);
                    best_pl  <= pl_r;
                    found    <= 1'b1;
                end
                S_N_INC:   n_r <= n_r + DW'(1);
                S_M_INC:   m_r <= m_r + MCW'(1);
                S_PL_NEXT: if (pl_r < hi_idx) pl_r <= pl_r + 4'd1;
                S_F_WT:    if (dv_done) freq_r <= dv_quo[FW-1:0];
                default: ;
            endcase
        end
    end

    // ---------------------------------------------------------------
    // Outputs
    // ---------------------------------------------------------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            no_sol   <= 1'b0;
            m_out    <= '0;
            n_out    <= '0;
            pl_out   <= '0;
            freq_out <= '0;
        end else begin
            if (state == S_IDLE && start) begin
                busy <= 1'b1;
                done <= 1'b0;
            end
            if (state == S_FIN) begin
                busy     <= 1'b0;
                done     <= 1'b1;
                no_sol   <= !found;
                m_out    <= best_m;
                n_out    <= best_n;
                pl_out   <= best_pl;
                freq_out <= freq_r;
            end
        end
    end
endmodule

// File: rtl/pllsrch_chk.sv
module pllsrch_chk #(
    parameter int unsigned FW     = 32,
    parameter int unsigned MW     = 8,
    parameter int unsigned NW     = 8,
    parameter int unsigned M_MIN  = 1,
    parameter int unsigned M_MAX  = 255,
    parameter int unsigned N_MIN  = 8,
    parameter int unsigned N_MAX  = 255,
    parameter int unsigned PL_MIN = 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          no_sol,
    input logic [MW-1:0] m_out,
    input logic [NW-1:0] n_out,
    input logic [3:0]    pl_out,
    input logic [FW-1:0] freq_out
);
    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R2
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R2
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy));

    // R12
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    // R12
    result_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (done || ($stable(m_out) && $stable(n_out) &&
                           $stable(pl_out) && $stable(freq_out))));

    // R6
    result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_sol) |-> ((m_out >= MW'(M_MIN)) && (m_out <= MW'(M_MAX)) &&
                               (n_out >= NW'(N_MIN)) && (n_out <= NW'(N_MAX)) &&
                               (pl_out <= 4'd13)));

    // R11
    nosol_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_sol) |-> ((m_out == MW'(M_MAX)) && (n_out == NW'(N_MIN)) &&
                              (pl_out == 4'(PL_MIN))));
endmodule

bind pll_coef_search pllsrch_chk #(
    .FW(FW), .MW(MW), .NW(NW),
    .M_MIN(M_MIN), .M_MAX(M_MAX), .N_MIN(N_MIN), .N_MAX(N_MAX), .PL_MIN(PL_MIN)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .no_sol   (no_sol),
    .m_out    (m_out),
    .n_out    (n_out),
    .pl_out   (pl_out),
    .freq_out (freq_out)
);

// File: tb/test_pll_coef_search.sv
`timescale 1ns/1ps
module test_pll_coef_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        fast_mode = 1'b0;
    logic [31:0] ref_khz = '0;
    logic [31:0] target_khz = '0;
    logic        busy, done, no_sol;
    logic [7:0]  m_out, n_out;
    logic [3:0]  pl_out;
    logic [31:0] freq_out;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pll_coef_search i_pll_coef_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fast_mode  (fast_mode),
        .ref_khz    (ref_khz),
        .target_khz (target_khz),
        .busy       (busy),
        .done       (done),
        .no_sol     (no_sol),
        .m_out      (m_out),
        .n_out      (n_out),
        .pl_out     (pl_out),
        .freq_out   (freq_out)
    );

    typedef struct packed {
        logic [31:0] rk;
        logic [31:0] tk;
        logic        fast;
        logic [7:0]  m;
        logic [7:0]  n;
        logic [3:0]  pl;
        logic [31:0] f;
        logic        ns;
    } vec_t;

    // Expected values worked out by hand from the requirements
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R8 R9: exact hit at divide 2 ends search on zero error
        '{32'd12000, 32'd600000,  1'b0, 8'd1,   8'd100, 4'd1, 32'd600000,  1'b0},
        // R7 R9: best fit keeps the second N (error 2000 beats 4000)
        '{32'd12000, 32'd700000,  1'b0, 8'd1,   8'd117, 4'd1, 32'd702000,  1'b0},
        // R10: fast mode stops at first N (1392000/4000 > 218)
        '{32'd12000, 32'd700000,  1'b1, 8'd1,   8'd116, 4'd1, 32'd696000,  1'b0},
        // R3 R4 R5: low clamp to 144000, index 6 divides by 8
        '{32'd12000, 32'd100000,  1'b0, 8'd1,   8'd96,  4'd6, 32'd144000,  1'b0},
        // R3 R5: high clamp to 2064000, VCO ceiling raised, index 0
        '{32'd12000, 32'd3000000, 1'b0, 8'd1,   8'd172, 4'd0, 32'd2064000, 1'b0},
        // R6 R10: M=1 skipped (u high), fast stop at M=2 N=78 index 2
        '{32'd38400, 32'd500000,  1'b1, 8'd2,   8'd78,  4'd2, 32'd499200,  1'b0},
        // R6 R9: best fit, later ties (error 800) do not replace
        '{32'd38400, 32'd500000,  1'b0, 8'd2,   8'd78,  4'd2, 32'd499200,  1'b0},
        // R11 R13: u below minimum everywhere, defaults reported
        '{32'd1000,  32'd600000,  1'b0, 8'd255, 8'd8,   4'd1, 32'd15,      1'b1}
    };

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (!done && k < 40000) begin
            @(negedge clk);
            k++;
        end
        chk("R2 done reached", 64'(done), 64'd1);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000 && !finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cycles, 190000);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 busy in reset", 64'(busy), 64'd0);
        chk("R1 done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy", 64'(busy), 64'd0);
        chk("R1 done", 64'(done), 64'd0);
        chk("R1 no_sol", 64'(no_sol), 64'd0);
        chk("R1 m_out", 64'(m_out), 64'd0);
        chk("R1 n_out", 64'(n_out), 64'd0);
        chk("R1 pl_out", 64'(pl_out), 64'd0);
        chk("R1 freq_out", 64'(freq_out), 64'd0);

        // Vector walk (R3..R11, R13)
        for (int v = 0; v < NV; v++) begin
            ref_khz    = VECS[v].rk;
            target_khz = VECS[v].tk;
            fast_mode  = VECS[v].fast;
            pulse_start();
            chk($sformatf("R2 busy after start v%0d", v), 64'(busy), 64'd1);
            wait_done();
            chk($sformatf("R6 R9 m v%0d", v), 64'(m_out), 64'(VECS[v].m));
            chk($sformatf("R7 R9 n v%0d", v), 64'(n_out), 64'(VECS[v].n));
            chk($sformatf("R4 R5 pl v%0d", v), 64'(pl_out), 64'(VECS[v].pl));
            chk($sformatf("R13 freq v%0d", v), 64'(freq_out), 64'(VECS[v].f));
            chk($sformatf("R11 no_sol v%0d", v), 64'(no_sol), 64'(VECS[v].ns));
        end

        // R2: start during busy is ignored, including changed inputs
        ref_khz = 32'd12000; target_khz = 32'd700000; fast_mode = 1'b0;
        pulse_start();
        repeat (5) @(negedge clk);
        ref_khz = 32'd38400; target_khz = 32'd500000; fast_mode = 1'b1;
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        chk("R2 still busy", 64'(busy), 64'd1);
        wait_done();
        chk("R2 ignored start m", 64'(m_out), 64'd1);
        chk("R2 ignored start n", 64'(n_out), 64'd117);
        chk("R2 ignored start freq", 64'(freq_out), 64'd702000);

        // R12: result held while idle
        repeat (10) @(negedge clk);
        chk("R12 done held", 64'(done), 64'd1);
        chk("R12 n held", 64'(n_out), 64'd117);
        chk("R12 busy low", 64'(busy), 64'd0);

        // R2: new start clears done, uses the current inputs
        pulse_start();
        chk("R2 done cleared", 64'(done), 64'd0);
        chk("R12 outputs frozen while busy", 64'(n_out), 64'd117);
        wait_done();
        chk("R10 second request n", 64'(n_out), 64'd78);
        chk("R13 second request freq", 64'(freq_out), 64'd499200);

        finished = 1;
        summary();
        $finish;
    end
endmodule